// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block rewrites every byte of a byte-addressable nonvolatile data array with its own current value, so that stored charge is restored without software walking the array. One pulse on `start` runs the whole pass. The block drives the request side of an array write controller: it selects the data space, raises write-enable and asks for interrupts to be masked. At each location it reads the byte, presents the two-byte unlock key, starts the write of that same byte, and waits until the controller's busy flag drops before moving on.

The pass begins at address zero. It ends when the address counter rolls over from its top value back to zero. On a clean finish, on an abort request, or on an error reported by the controller, the block drops write-enable, data-space select and the interrupt-mask request, and gives a one-cycle `done` pulse. A controller error also leaves a sticky error flag set until the next start. Deciding when a refresh is needed is left to the surrounding system.

Top module: `nvm_refresh_seq`

## Requirements
- R1: While reset is high, and after it until a start, `busy`, `done`, `err_flag`, `irq_mask`, `ctl_data_sel`, `ctl_wr_en`, `ctl_rd_req`, `ctl_key_wr` and `ctl_wr_req` are all 0.
- R2: A `start` pulse in idle begins a pass at address 0. `ctl_data_sel`, `ctl_wr_en` and `irq_mask` are 1 before the first read and stay 1 at every read, key and write request of the pass.
- R3: For each address the order is: a `ctl_rd_req`; then two `ctl_key_wr` strobes on back-to-back cycles carrying 8'h55 and then 8'hAA; then, on the next cycle, a `ctl_wr_req` whose `ctl_wr_data` is the byte returned one cycle after the read request.
- R4: After a write request, no further request is issued while `ctl_busy` is 1. The next address is the previous address plus one.
- R5: A full pass writes each of the 2^ADDR_W locations exactly once, in rising order. It ends after the all-ones address, and the array contents are unchanged afterwards.
- R6: At the end of every pass `done` is 1 for exactly one cycle. In that cycle and afterwards, `ctl_wr_en`, `ctl_data_sel` and `irq_mask` are 0. `busy` is 0 on the following cycle.
- R7: A `start` seen while `busy` is 1 has no effect: the pass still writes each location once and gives one `done` pulse.
- R8: If `ctl_err` is 1 during a pass, no further request is issued, the pass ends with `done`, and `err_flag` becomes 1. `err_flag` stays 1 until the next accepted `start`, which clears it.
- R9: An `abort_req` pulse during a pass lets the write already started complete. After that write no further read or write is issued, the pass ends with `done`, and `err_flag` stays 0.
- R10: Correct operation does not depend on how many cycles the controller holds `ctl_busy` after a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a refresh pass (accepted only in idle) |
| abort_req | input | 1 | Stop after the write in progress |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| err_flag | output | 1 | Sticky: last pass ended on a controller error |
| irq_mask | output | 1 | Request to hold interrupts masked |
| ctl_data_sel | output | 1 | Select the data array (not program or configuration space) |
| ctl_wr_en | output | 1 | Write-enable to the controller |
| ctl_addr | output | ADDR_W | Current array address |
| ctl_rd_req | output | 1 | Read request; data expected the next cycle |
| ctl_rd_data | input | DATA_W | Read data from the controller |
| ctl_key_wr | output | 1 | Unlock key strobe |
| ctl_key_data | output | 8 | Unlock key byte |
| ctl_wr_req | output | 1 | Start a write of `ctl_wr_data` at `ctl_addr` |
| ctl_wr_data | output | DATA_W | Byte to write |
| ctl_busy | input | 1 | Write in progress; must be 1 from the cycle after `ctl_wr_req` |
| ctl_err | input | 1 | Controller error |

## Verification
The pass is run against a behavioural array filled with three different images: an address-dependent mix, all zeros and all ones. With the all-zeros and all-ones images, a stuck or shifted data path still gives back the same bytes, so it shows up only as missed, repeated or out-of-order writes. The mixed image exposes a wrong byte written back. The array's write latency is varied from one to nine cycles, which tells apart a sequencer that really waits on busy from one that assumes a fixed delay. Abort, a controller error and stray start pulses are each placed in the middle of a pass. The number of writes that follows shows whether the stop came at the right point.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_CAPT,
        ST_KEY1,
        ST_KEY2,
        ST_WRITE,
        ST_WAIT,
        ST_NEXT,
        ST_END
    } seq_state_e;

    typedef struct packed {
        logic       data_sel;
        logic       wr_en;
        logic       mask;
        logic       rd_req;
        logic       key_wr;
        logic [7:0] key_data;
        logic       wr_req;
    } ctl_drive_t;

    function automatic logic in_run(input seq_state_e s);
        return (s != ST_IDLE) && (s != ST_END);
    endfunction

    function automatic ctl_drive_t decode_drive(input seq_state_e s);
        ctl_drive_t d;
        d          = '0;
        d.data_sel = in_run(s);
        d.wr_en    = in_run(s);
        d.mask     = in_run(s);
        d.rd_req   = (s == ST_READ);
        d.key_wr   = (s == ST_KEY1) || (s == ST_KEY2);
        d.key_data = (s == ST_KEY1) ? KEY_FIRST :
                     (s == ST_KEY2) ? KEY_SECOND : 8'h00;
        d.wr_req   = (s == ST_WRITE);
        return d;
    endfunction

endpackage

// File: rtl/refresh_addr_ctr.sv
module refresh_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) addr <= '0;
        else if (inc)   addr <= addr + 1'b1;
    end

    assign last = (addr == TOP);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import refresh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort_req,
    input  logic              ctl_busy,
    input  logic              ctl_err,
    input  logic              addr_last,
    input  logic [DATA_W-1:0] rd_data,
    output logic              addr_clr,
    output logic              addr_inc,
    output ctl_drive_t        drive,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err_flag
);
    seq_state_e        state;
    logic [DATA_W-1:0] hold;
    logic              abort_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            hold       <= '0;
            err_flag   <= 1'b0;
            abort_pend <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state      <= ST_SETUP;
                err_flag   <= 1'b0;
                abort_pend <= 1'b0;
            end
        end else if (state == ST_END) begin
            state <= ST_IDLE;
        end else if (ctl_err) begin
            state    <= ST_END;
            err_flag <= 1'b1;
        end else begin
            if (abort_req) abort_pend <= 1'b1;
            unique case (state)
                ST_SETUP: state <= ST_READ;
                ST_READ:  state <= ST_CAPT;
                ST_CAPT: begin
                    hold  <= rd_data;
                    state <= ST_KEY1;
                end
                ST_KEY1:  state <= ST_KEY2;
                ST_KEY2:  state <= ST_WRITE;
                ST_WRITE: state <= ST_WAIT;
                ST_WAIT:  if (!ctl_busy) state <= ST_NEXT;
                ST_NEXT:  state <= (addr_last || abort_pend) ? ST_END : ST_READ;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign drive    = decode_drive(state);
    assign wr_data  = hold;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_END);
    assign addr_clr = (state == ST_IDLE) && start;
    assign addr_inc = (state == ST_NEXT) && !ctl_err;

    // R3
    key_order_chk: assert property (@(posedge clk) disable iff (rst)
        (drive.key_wr && drive.key_data == KEY_SECOND)
            |-> $past(drive.key_wr && drive.key_data == KEY_FIRST));

    // R3
    wr_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        drive.wr_req |-> $past(drive.key_wr && drive.key_data == KEY_SECOND));

    // R2
    wr_guarded_chk: assert property (@(posedge clk) disable iff (rst)
        (drive.wr_req || drive.rd_req) |-> (drive.mask && drive.wr_en && drive.data_sel));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(ctl_err));

    // R4
    no_req_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_busy |-> !(drive.rd_req || drive.wr_req));

endmodule

// File: rtl/nvm_refresh_seq.sv
module nvm_refresh_seq
    import refresh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort_req,
    output logic              busy,
    output logic              done,
    output logic              err_flag,
    output logic              irq_mask,
    output logic              ctl_data_sel,
    output logic              ctl_wr_en,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic              ctl_rd_req,
    input  logic [DATA_W-1:0] ctl_rd_data,
    output logic              ctl_key_wr,
    output logic [7:0]        ctl_key_data,
    output logic              ctl_wr_req,
    output logic [DATA_W-1:0] ctl_wr_data,
    input  logic              ctl_busy,
    input  logic              ctl_err
);
    ctl_drive_t drv;
    logic       a_clr;
    logic       a_inc;
    logic       a_last;

    refresh_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .clr  (a_clr),
        .inc  (a_inc),
        .addr (ctl_addr),
        .last (a_last)
    );

    refresh_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .abort_req (abort_req),
        .ctl_busy  (ctl_busy),
        .ctl_err   (ctl_err),
        .addr_last (a_last),
        .rd_data   (ctl_rd_data),
        .addr_clr  (a_clr),
        .addr_inc  (a_inc),
        .drive     (drv),
        .wr_data   (ctl_wr_data),
        .busy      (busy),
        .done      (done),
        .err_flag  (err_flag)
    );

    assign irq_mask     = drv.mask;
    assign ctl_data_sel = drv.data_sel;
    assign ctl_wr_en    = drv.wr_en;
    assign ctl_rd_req   = drv.rd_req;
    assign ctl_key_wr   = drv.key_wr;
    assign ctl_key_data = drv.key_data;
    assign ctl_wr_req   = drv.wr_req;

endmodule

// File: tb/nvm_refresh_seq_tb.sv
module nvm_refresh_seq_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              abort_req = 1'b0;
    logic              busy, done, err_flag, irq_mask;
    logic              ctl_data_sel, ctl_wr_en, ctl_rd_req, ctl_key_wr, ctl_wr_req;
    logic [ADDR_W-1:0] ctl_addr;
    logic [DATA_W-1:0] ctl_rd_data = '0;
    logic [7:0]        ctl_key_data;
    logic [DATA_W-1:0] ctl_wr_data;
    logic              ctl_busy = 1'b0;
    logic              ctl_err = 1'b0;

    always #4 clk = ~clk;

    nvm_refresh_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .abort_req(abort_req),
        .busy(busy), .done(done), .err_flag(err_flag), .irq_mask(irq_mask),
        .ctl_data_sel(ctl_data_sel), .ctl_wr_en(ctl_wr_en), .ctl_addr(ctl_addr),
        .ctl_rd_req(ctl_rd_req), .ctl_rd_data(ctl_rd_data),
        .ctl_key_wr(ctl_key_wr), .ctl_key_data(ctl_key_data),
        .ctl_wr_req(ctl_wr_req), .ctl_wr_data(ctl_wr_data),
        .ctl_busy(ctl_busy), .ctl_err(ctl_err)
    );

    // behavioural array and write controller
    logic [DATA_W-1:0] mem   [DEPTH];
    logic [DATA_W-1:0] image [DEPTH];
    int                wcnt  [DEPTH];
    int  lat = 3;
    int  err_at = 0;
    int  bsy_left = 0;
    int  wr_total = 0;
    int  bad_seq = 0;
    int  order_bad = 0;
    int  exp_addr = 0;
    int  done_cnt = 0;
    int  pass_cnt = 0;
    int  fail_cnt = 0;
    logic k1_seen = 1'b0;
    logic k2_ok   = 1'b0;

    always @(posedge clk) begin
        if (ctl_rd_req) ctl_rd_data <= mem[ctl_addr];
        k1_seen <= ctl_key_wr && ctl_key_data == 8'h55;
        k2_ok   <= ctl_key_wr && ctl_key_data == 8'hAA && k1_seen;
        if ((ctl_rd_req || ctl_wr_req) && (ctl_busy || !irq_mask || !ctl_wr_en || !ctl_data_sel))
            bad_seq <= bad_seq + 1;
        ctl_err <= 1'b0;
        if (ctl_wr_req) begin
            if (!k2_ok) bad_seq <= bad_seq + 1;
            if (int'(ctl_addr) != exp_addr) order_bad <= order_bad + 1;
            exp_addr <= int'(ctl_addr) + 1;
            mem[ctl_addr]  <= ctl_wr_data;
            wcnt[ctl_addr] <= wcnt[ctl_addr] + 1;
            wr_total <= wr_total + 1;
            ctl_busy <= 1'b1;
            bsy_left <= lat;
            if (wr_total + 1 == err_at) ctl_err <= 1'b1;
        end else if (ctl_busy) begin
            if (bsy_left <= 1) ctl_busy <= 1'b0;
            bsy_left <= bsy_left - 1;
        end
    end

    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        pass_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int kind);
        for (int a = 0; a < DEPTH; a++) begin
            case (kind)
                0: image[a] = DATA_W'((a * 37) ^ 8'h3C);
                1: image[a] = '0;
                default: image[a] = '1;
            endcase
            mem[a]  = image[a];
            wcnt[a] = 0;
        end
        wr_total  = 0;
        bad_seq   = 0;
        order_bad = 0;
        exp_addr  = 0;
        done_cnt  = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic check_end_state(input string req);
        bit ok;
        ok = !ctl_wr_en && !irq_mask && !ctl_data_sel;
        check(ok, req, {ctl_wr_en, irq_mask, ctl_data_sel}, 0);
        @(negedge clk);
        check(!busy, req, busy, 0);
    endtask

    task automatic check_image(input string req);
        int diff = 0;
        int once = 0;
        for (int a = 0; a < DEPTH; a++) begin
            if (mem[a] != image[a]) diff++;
            if (wcnt[a] != 1) once++;
        end
        check(diff == 0, req, diff, 0);
        check(once == 0, req, once, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !err_flag && !irq_mask, "R1", {busy, done, err_flag, irq_mask}, 0);
        check(!ctl_wr_en && !ctl_data_sel && !ctl_rd_req && !ctl_key_wr && !ctl_wr_req, "R1",
              {ctl_wr_en, ctl_data_sel, ctl_rd_req, ctl_key_wr, ctl_wr_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && ctl_addr == 0, "R1", busy, 0);
    endtask

    task automatic t_full(input int kind, input int l, input string tag);
        bit ok;
        lat = l;
        fill(kind);
        pulse_start();
        check(busy && irq_mask && ctl_wr_en && ctl_data_sel, "R2",
              {busy, irq_mask, ctl_wr_en, ctl_data_sel}, 15);
        wait_done(ok);
        check(ok, {tag, " R6 done"}, ok, 1);
        check(wr_total == DEPTH, "R5", wr_total, DEPTH);
        check(bad_seq == 0, "R3", bad_seq, 0);
        check(order_bad == 0, "R4", order_bad, 0);
        check(!err_flag, "R8", err_flag, 0);
        check_end_state("R6");
        check_image({tag, " R5"});
        repeat (3) @(negedge clk);
        check(done_cnt == 1, "R6", done_cnt, 1);
    endtask

    task automatic t_start_busy();
        bit ok;
        lat = 2;
        fill(0);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        repeat (400) @(negedge clk);
        start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        repeat (4) @(negedge clk);
        check(wr_total == DEPTH, "R7", wr_total, DEPTH);
        check(done_cnt == 1, "R7", done_cnt, 1);
        check_image("R7");
    endtask

    task automatic t_abort();
        bit ok;
        lat = 4;
        fill(0);
        pulse_start();
        while (wr_total < 10) @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        wait_done(ok);
        check(ok, "R9", ok, 1);
        repeat (6) @(negedge clk);
        check(wr_total == 10, "R9", wr_total, 10);
        check(!err_flag, "R9", err_flag, 0);
        check(done_cnt == 1 && !busy, "R9", done_cnt, 1);
    endtask

    task automatic t_error();
        bit ok;
        lat = 3;
        fill(0);
        err_at = 5;
        pulse_start();
        wait_done(ok);
        check(ok, "R8", ok, 1);
        check(!ctl_wr_en && !irq_mask, "R8", {ctl_wr_en, irq_mask}, 0);
        repeat (6) @(negedge clk);
        err_at = 0;
        check(wr_total == 5, "R8", wr_total, 5);
        check(err_flag, "R8", err_flag, 1);
        check(done_cnt == 1, "R8", done_cnt, 1);
        fill(0);
        pulse_start();
        check(!err_flag, "R8 cleared", err_flag, 0);
        wait_done(ok);
        repeat (2) @(negedge clk);
        check(wr_total == DEPTH && !err_flag, "R8", wr_total, DEPTH);
    endtask

    initial begin
        #1500000;
        fail_cnt++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", pass_cnt, fail_cnt);
        $finish;
    end

    initial begin
        t_reset();
        t_full(0, 3, "mix");
        t_full(1, 1, "R10 zeros");
        t_full(2, 9, "R10 ones");
        t_start_busy();
        t_abort();
        t_error();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", pass_cnt, fail_cnt);
        $finish;
    end

endmodule